// File: doc/BRIEF.md
# Bus-Matching Read Unpacker with Byte Reordering

This block connects the read side of a FIFO that stores 36-bit long words (four 9-bit bytes each) to an output bus. That bus may be narrower than the stored word. Each stored word is taken whole from the FIFO. The block can first reorder its bytes in one of four patterns. It then presents the word through a registered 36-bit output, in one of three ways:

- as one full long word;
- as two 18-bit pieces;
- as four 9-bit pieces.

Narrow pieces go either on the most significant lanes or on the least significant lanes.

Size and lane-side selections pass through one register stage before they govern a read. The first read in a narrow format pops a word and shows its first piece. The pieces that remain are held inside the block, and later reads in the same format deliver them. One size code is reserved for a side access that bypasses this path. That code freezes the unpacking state, so an interrupted sequence continues on the next read.

Top module: `bus_match_unpacker`

## Requirements
- R1: While reset is asserted and after it is released, `out_data` is all zeros and `fifo_pop` is low until a read is requested.
- R2: The size code 00 selects long-word mode. In this mode every read with the FIFO not empty raises `fifo_pop` and loads the whole reordered word into `out_data` at that clock edge.
- R3: A read is governed by the size and lane-side selects that were present at the previous rising edge. Select changes made in the same cycle as a read do not affect that read.
- R4: Size code 01 selects 18-bit pieces, and 10 selects 9-bit pieces. When `big_sel`=1, the most significant piece comes first and every piece is placed on the top lanes (bits 35:18 or 35:27). When `big_sel`=0, the least significant piece comes first and every piece is placed on the bottom lanes (bits 17:0 or 8:0).
- R5: In a narrow mode, only the read that fetches a new word raises `fifo_pop`. Later reads deliver the held pieces without popping. A fresh word is popped once every piece has been delivered.
- R6: A read whose size or lane side differs from that of the held word pops a new word, and the pieces still held are discarded.
- R7: In a narrow mode, output lanes not used by the current piece keep their previous value.
- R8: The reorder codes are: 00 leaves the bytes in place, 01 reverses all four bytes, 10 exchanges the two 18-bit halves, and 11 exchanges the two bytes within each half. Bit order inside a byte never changes.
- R9: `swap_sel` is used only on a read that pops a new word. Its value on later piece reads of that word has no effect.
- R10: When reordering and narrowing are both active, the bytes are reordered first, and the reordered word is then split into pieces.
- R11: A read with size code 11 does not pop, leaves `out_data` unchanged, and keeps the held pieces. The next read in the previous format delivers the next held piece.
- R12: `fifo_pop` is never raised while `fifo_empty` is high. A read that needs a new word while the FIFO is empty leaves the output and the held state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request for this cycle |
| size_sel | input | 2 | Output size: 00 long, 01 18-bit, 10 9-bit, 11 side access |
| big_sel | input | 1 | 1 = narrow pieces on top lanes, most significant piece first |
| swap_sel | input | 2 | Byte reorder code, used on a read that pops a new word |
| fifo_empty | input | 1 | FIFO has no word to give |
| fifo_data | input | 36 | Word at the head of the FIFO |
| fifo_pop | output | 1 | Removes the head word at this rising edge |
| out_data | output | 36 | Registered output bus |

## Verification
The hardest situation to reach is a side-access read, or a format change, that lands in the middle of a piece sequence. The test must also show that held pieces survive the side access and are dropped on a format change. Because the selects pass through one register stage, the stimulus sets each new size one cycle before the read that must use it. It also changes `size_sel` and `rd_en` together in one cycle, to show that the older selection governs that read. `swap_sel` is deliberately changed between the pieces of one word, and the FIFO is drained to empty while reads continue.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_SIDE = 2'b11
  } size_e;

  typedef struct packed {
    size_e size;
    logic  big;
  } fmt_t;

  // Number of bytes carried by one output piece for a given size.
  function automatic int piece_bytes(size_e s, int nb);
    case (s)
      SZ_WORD: return nb / 2;
      SZ_BYTE: return 1;
      default: return nb;
    endcase
  endfunction

endpackage

// File: rtl/bmu_swap.sv
module bmu_swap #(
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4
) (
  input  logic [BYTE_W*NBYTES-1:0] din,
  input  logic [1:0]               code,
  output logic [BYTE_W*NBYTES-1:0] dout
);
  localparam int HALF = NBYTES / 2;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam int SRC_REV = NBYTES - 1 - i;
    localparam int SRC_HSW = (i + HALF) % NBYTES;
    localparam int SRC_INH = (i / HALF) * HALF + (HALF - 1 - (i % HALF));
    logic [BYTE_W-1:0] lane;

    always_comb begin
      case (code)
        2'b01:   lane = din[SRC_REV*BYTE_W +: BYTE_W];
        2'b10:   lane = din[SRC_HSW*BYTE_W +: BYTE_W];
        2'b11:   lane = din[SRC_INH*BYTE_W +: BYTE_W];
        default: lane = din[i*BYTE_W +: BYTE_W];
      endcase
    end

    assign dout[i*BYTE_W +: BYTE_W] = lane;
  end

endmodule

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int CW = $clog2(NBYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    size_sel,
  input  logic          big_sel,
  input  logic          fifo_empty,
  output logic          fetch,
  output logic          advance,
  output fmt_t          cur_fmt,
  output logic [CW-1:0] piece_idx
);
  size_e         size_q;
  logic          big_q;
  fmt_t          held_fmt, held_fmt_n;
  logic [CW-1:0] left_q, left_n;
  logic [CW-1:0] held_cnt, cur_cnt;
  logic          path_rd, need_new;

  assign cur_fmt = '{size: size_q, big: big_q};

  always_comb begin
    held_cnt   = CW'(NBYTES / piece_bytes(held_fmt.size, NBYTES));
    cur_cnt    = CW'(NBYTES / piece_bytes(size_q, NBYTES));
    path_rd    = rd_en && (size_q != SZ_SIDE);
    need_new   = (left_q == '0) || (cur_fmt != held_fmt);
    fetch      = path_rd && need_new && !fifo_empty;
    advance    = path_rd && !need_new;
    piece_idx  = fetch ? '0 : (held_cnt - left_q);
    left_n     = left_q;
    held_fmt_n = held_fmt;
    if (fetch) begin
      left_n     = cur_cnt - CW'(1);
      held_fmt_n = cur_fmt;
    end else if (advance) begin
      left_n = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= SZ_LONG;
      big_q    <= 1'b0;
      held_fmt <= '{size: SZ_LONG, big: 1'b0};
      left_q   <= '0;
    end else begin
      size_q   <= size_e'(size_sel);
      big_q    <= big_sel;
      held_fmt <= held_fmt_n;
      left_q   <= left_n;
    end
  end

endmodule

// File: rtl/bmu_lanes.sv
module bmu_lanes
  import bmu_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int W  = BYTE_W * NBYTES,
  localparam int CW = $clog2(NBYTES) + 1
) (
  input  logic [W-1:0]      src,
  input  fmt_t              fmt,
  input  logic [CW-1:0]     piece_idx,
  output logic [W-1:0]      lane_data,
  output logic [NBYTES-1:0] lane_en
);
  always_comb begin
    int kb;
    int s;
    lane_data = '0;
    lane_en   = '0;
    kb        = piece_bytes(fmt.size, NBYTES);
    for (int j = 0; j < NBYTES; j++) begin
      s = 0;
      if (fmt.big) begin
        if (j >= NBYTES - kb) begin
          lane_en[j] = 1'b1;
          s          = j - kb * int'(piece_idx);
        end
      end else if (j < kb) begin
        lane_en[j] = 1'b1;
        s          = j + kb * int'(piece_idx);
      end
      if (lane_en[j]) lane_data[j*BYTE_W +: BYTE_W] = src[s*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/bus_match_unpacker.sv
module bus_match_unpacker
  import bmu_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int W  = BYTE_W * NBYTES,
  localparam int CW = $clog2(NBYTES) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic [1:0]   size_sel,
  input  logic         big_sel,
  input  logic [1:0]   swap_sel,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_data,
  output logic         fifo_pop,
  output logic [W-1:0] out_data
);
  logic              fetch, advance;
  fmt_t              cur_fmt;
  logic [CW-1:0]     piece_idx;
  logic [W-1:0]      swapped, held_q, src;
  logic [W-1:0]      lane_data;
  logic [NBYTES-1:0] lane_en;

  bmu_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .size_sel   (size_sel),
    .big_sel    (big_sel),
    .fifo_empty (fifo_empty),
    .fetch      (fetch),
    .advance    (advance),
    .cur_fmt    (cur_fmt),
    .piece_idx  (piece_idx)
  );

  bmu_swap #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_swap (
    .din  (fifo_data),
    .code (swap_sel),
    .dout (swapped)
  );

  assign src      = fetch ? swapped : held_q;
  assign fifo_pop = fetch;

  bmu_lanes #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_lanes (
    .src       (src),
    .fmt       (cur_fmt),
    .piece_idx (piece_idx),
    .lane_data (lane_data),
    .lane_en   (lane_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (fetch) begin
      held_q <= swapped;
    end
  end

  for (genvar j = 0; j < NBYTES; j++) begin : g_out
    logic lane_ce;
    assign lane_ce = (fetch || advance) && lane_en[j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_data[j*BYTE_W +: BYTE_W] <= '0;
      end else if (lane_ce) begin
        out_data[j*BYTE_W +: BYTE_W] <= lane_data[j*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/bus_match_unpacker_chk.sv
module bus_match_unpacker_chk #(
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int W = BYTE_W * NBYTES
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_en,
  input logic [1:0]   size_sel,
  input logic         big_sel,
  input logic         fifo_empty,
  input logic         fifo_pop,
  input logic [W-1:0] out_data
);

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);  // R12

  AST_POP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> rd_en);  // R5

  AST_LONG_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fifo_empty && $past(rst_n) && $past(size_sel) == 2'b00) |-> fifo_pop);  // R2

  AST_SIDE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rst_n) && $past(size_sel) == 2'b11) |-> !fifo_pop);  // R11

  AST_SIDE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rst_n) && $past(size_sel) == 2'b11) |=> $stable(out_data));  // R11

  AST_BYTE_TOP_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rst_n) && $past(size_sel) == 2'b10 && $past(big_sel))
      |=> $stable(out_data[W-BYTE_W-1:0]));  // R7

endmodule

bind bus_match_unpacker bus_match_unpacker_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .size_sel   (size_sel),
  .big_sel    (big_sel),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .out_data   (out_data)
);

// File: tb/sim_bus_match_unpacker.sv
`timescale 1ns/1ps
module sim_bus_match_unpacker;
  localparam int W = 36;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, rd_en, big_sel, fifo_empty, fifo_pop;
  logic [1:0]   size_sel, swap_sel;
  logic [W-1:0] fifo_data, out_data;

  bus_match_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .size_sel(size_sel),
    .big_sel(big_sel), .swap_sel(swap_sel), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .out_data(out_data)
  );

  logic [W-1:0] fq[$];
  logic         pop_seen;
  always @(posedge clk) pop_seen <= fifo_pop;

  bit           exp_pop_q[$];
  logic [W-1:0] exp_out_q[$];
  string        tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [1:0]   m_sq, m_hs;
  logic         m_bq, m_hb;
  int           m_rem;
  logic [W-1:0] m_held, m_out;

  function automatic logic [W-1:0] swap_ref(logic [W-1:0] w, logic [1:0] c);
    case (c)
      2'b01:   return {w[8:0], w[17:9], w[26:18], w[35:27]};
      2'b10:   return {w[17:0], w[35:18]};
      2'b11:   return {w[26:18], w[35:27], w[8:0], w[17:9]};
      default: return w;
    endcase
  endfunction

  function automatic int npieces(logic [1:0] s);
    return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
  endfunction

  function automatic void place(int p);
    int pw;
    pw = (m_hs == 2'b01) ? 18 : (m_hs == 2'b10) ? 9 : 36;
    for (int b = 0; b < pw; b++) begin
      if (m_hb) m_out[W-pw+b] = m_held[W-pw*(p+1)+b];
      else      m_out[b]      = m_held[pw*p+b];
    end
  endfunction

  function automatic logic [W-1:0] mk(int n);
    return {9'(9'h100 | (16*n+3)), 9'(16*n+2), 9'(16*n+1), 9'(16*n)};
  endfunction

  task automatic refresh_fifo();
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() == 0) ? '0 : fq[0];
  endtask

  task automatic fill(int first, int count);
    for (int i = 0; i < count; i++) fq.push_back(mk(first + i));
    refresh_fifo();
  endtask

  // driver: one call per clock edge; pushes the expected pop and output
  task automatic step(bit rd, logic [1:0] sz, bit bg, logic [1:0] sw, string tag);
    bit ep;
    bit nf;
    @(negedge clk);
    if (pop_seen) void'(fq.pop_front());
    refresh_fifo();
    rd_en = rd; size_sel = sz; big_sel = bg; swap_sel = sw;
    ep = 1'b0;
    if (rd && m_sq != 2'b11) begin
      nf = (m_rem == 0) || (m_sq != m_hs) || (m_bq != m_hb);
      if (nf) begin
        if (fq.size() != 0) begin
          ep     = 1'b1;
          m_held = swap_ref(fq[0], sw);
          m_hs   = m_sq;
          m_hb   = m_bq;
          m_rem  = npieces(m_sq) - 1;
          place(0);
        end
      end else begin
        place(npieces(m_hs) - m_rem);
        m_rem--;
      end
    end
    m_sq = sz;
    m_bq = bg;
    exp_pop_q.push_back(ep);
    exp_out_q.push_back(m_out);
    tag_q.push_back(tag);
  endtask

  // monitor: pop is sampled before the edge, output after it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_pop_q.size() > 0) begin
        bit           ep, ap;
        logic [W-1:0] eo;
        string        tg;
        ep = exp_pop_q.pop_front();
        eo = exp_out_q.pop_front();
        tg = tag_q.pop_front();
        ap = fifo_pop;
        @(posedge clk);
        #1;
        n_cmp++;
        if (ap !== ep || out_data !== eo) begin
          n_bad++;
          $display("FAIL %s: pop=%0b out=%h expected pop=%0b out=%h", tg, ap, out_data, ep, eo);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; size_sel = 2'b00; big_sel = 1'b0; swap_sel = 2'b00;
    m_sq = 2'b00; m_hs = 2'b00; m_bq = 1'b0; m_hb = 1'b0; m_rem = 0;
    m_held = '0; m_out = '0;
    fq.delete();
    fill(1, 11);
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_data !== '0 || fifo_pop !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: pop=%0b out=%h expected pop=0 out=0 (in reset)", fifo_pop, out_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    n_cmp++;
    if (out_data !== '0 || fifo_pop !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: pop=%0b out=%h expected pop=0 out=0 (after reset)", fifo_pop, out_data);
    end

    step(0, 2'b00, 0, 2'b00, "R1");
    // long words under every reorder code
    step(1, 2'b00, 0, 2'b00, "R2");
    step(1, 2'b00, 0, 2'b01, "R8");
    step(1, 2'b00, 0, 2'b10, "R8");
    step(1, 2'b00, 0, 2'b11, "R8");
    // select changes with the read: old long format still applies
    step(1, 2'b01, 1, 2'b00, "R3");
    // 18-bit, top lanes; swap changed between pieces
    step(1, 2'b01, 1, 2'b01, "R4");
    step(1, 2'b01, 1, 2'b10, "R9");
    step(1, 2'b01, 1, 2'b00, "R5");
    // side access in the middle, then resume
    step(0, 2'b11, 0, 2'b00, "R11");
    step(1, 2'b01, 1, 2'b00, "R11");
    step(1, 2'b01, 1, 2'b11, "R11");
    // 9-bit, bottom lanes
    step(0, 2'b10, 0, 2'b00, "R7");
    step(1, 2'b10, 0, 2'b00, "R4");
    step(1, 2'b10, 0, 2'b01, "R7");
    step(1, 2'b10, 0, 2'b00, "R7");
    step(1, 2'b10, 0, 2'b00, "R7");
    step(1, 2'b10, 0, 2'b00, "R5");
    // 9-bit, top lanes, reorder then split, then format change mid-word
    step(0, 2'b10, 1, 2'b01, "R10");
    step(1, 2'b10, 1, 2'b01, "R10");
    step(1, 2'b10, 1, 2'b00, "R10");
    step(1, 2'b01, 0, 2'b00, "R10");
    step(1, 2'b01, 0, 2'b10, "R6");
    step(1, 2'b01, 0, 2'b00, "R6");
    // drain and read while empty
    step(0, 2'b00, 0, 2'b00, "R12");
    step(1, 2'b00, 0, 2'b00, "R12");
    step(1, 2'b00, 0, 2'b00, "R12");
    step(1, 2'b00, 0, 2'b00, "R12");
    step(0, 2'b00, 0, 2'b00, "R12");
    fill(40, 1);
    step(1, 2'b00, 0, 2'b11, "R12");
    step(0, 2'b00, 0, 2'b00, "R2");
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule